// File: doc/BRIEF.md
# Multi-Select SPI Master Controller

This block is a serial peripheral interface master that shifts words of 8 to 16 bits, most significant bit first, to one of several external devices. Each of the four device-select slots has its own settings: word length, clock idle level, sampling edge, a lead-in delay from select assertion to the first clock edge, and a rest delay after each word before the next one may start. Software picks a slot through a target register, and each word written to the transmit register is shifted with that slot's settings.

The select outputs work in two ways. In direct mode exactly one of the four lines goes low for the chosen slot. In coded mode the four lines carry a 4-bit device code for an external decoder, so up to 15 devices can be reached; the all-ones code means no device is selected. Received words go to a holding register together with the select code that was in use. An overrun flag reports a word that arrived before the previous one was read.

Two request strobes let a pair of DMA channels feed the transmit buffer and drain the holding register. With fault detection switched on, a low level on the slave-select input while the block is the master sets a sticky fault flag. It also aborts any word in progress and withdraws the output enable for the serial pins.

Top module: `spi_multi_master`

## Requirements
- R1: After reset, `cs_n` is 4'hF, `drv_en`, `tx_req` and `rx_req` are low, and the status word (address 4) reads 0.
- R2: In direct mode (CTRL bit 1 = 0), during a word exactly one `cs_n` line is low: line number TGT[1:0]. All four lines are high between words.
- R3: In coded mode (CTRL bit 1 = 1), `cs_n` carries TGT[3:0] during a word and 4'hF otherwise. The settings used are those of slot TGT[1:0].
- R4: A slot's word length is 8 + min(CFG[3:0], 8) bits. `mosi` shifts the transmit word out MSB first, and the received word is right-aligned in RXD[15:0] with the upper bits zero.
- R5: CFG bit 4 sets the idle level of `sclk`. With CFG bit 5 = 0, both sides sample on the first edge of each clock period; with bit 5 = 1 they sample on the second edge.
- R6: A lead-in delay of D (CFG[15:8]) moves the first `sclk` edge exactly D system cycles later than a delay of 0 would.
- R7: A rest delay of D (CFG[23:16]) keeps `cs_n` high exactly D system cycles longer between back-to-back words than a delay of 0 would.
- R8: Each `sclk` half period lasts DIV system cycles (CTRL[15:8]). With DIV = 0 no word starts, and a written word stays pending (STAT bit 1 = 1).
- R9: The holding register gives the data in RXD[15:0] and the select code in RXD[19:16] and STAT[11:8]. STAT bit 0 shows it is full, and a read of RXD (address 3) empties it.
- R10: A word that completes while the holding register is still full sets STAT bit 2 and replaces the held data. A read of STAT clears the flag.
- R11: With CTRL bits 0 and 2 set, a low `ss_n_in` sets STAT bit 3 within 4 cycles, drops `drv_en`, releases `cs_n` and aborts the word. The flag clears on a read of STAT. With CTRL bit 2 = 0, `ss_n_in` has no effect.
- R12: `tx_req` is high only when the block is enabled, has no fault and has no pending transmit word. `rx_req` is high while the holding register is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (for read side effects) |
| reg_addr | input | 4 | Register address: 0 CTRL, 1 TGT, 2 TXD, 3 RXD, 4 STAT, 8..11 CFG slot 0..3 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Device selects, direct or coded |
| ss_n_in | input | 1 | Slave-select input watched for mode faults |
| drv_en | output | 1 | Output enable for the serial pins |
| tx_req | output | 1 | Transmit DMA request |
| rx_req | output | 1 | Receive DMA request |

## Verification
A register write takes effect at the next clock edge, and a pending word moves to the lead-in phase one edge after that. The select therefore falls two edges after the transmit write. A mode fault passes through a two-stage synchronizer and is set on the third edge after `ss_n_in` falls, so the bench looks for it after four cycles. `rx_req` rises on the same edge as the last clock edge of a word. The bench waits for that port level before it reads the holding register. The delays are measured at falling clock edges and compared as differences between two settings, so the check does not depend on the fixed overhead cycles of the state sequence.

// File: rtl/spi_multi_master.sv
module spi_multi_master #(
  parameter int DIV_W = 8,
  parameter int DLY_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  cs_n,
  input  logic        ss_n_in,
  output logic        drv_en,
  output logic        tx_req,
  output logic        rx_req
);
  localparam int DW    = 16;
  localparam int NCS   = 4;
  localparam int SU_LO = 8;
  localparam int GP_LO = SU_LO + DLY_W;
  localparam int CW    = (DIV_W > DLY_W) ? DIV_W : DLY_W;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_REST} st_t;

  function automatic logic [4:0] len_of(input logic [3:0] c);
    return (c > 4'd8) ? 5'd16 : 5'd8 + {1'b0, c};
  endfunction

  st_t              st_q;
  logic             en_q, enc_q, mfe_q, fault_q, ovr_q, tx_full_q, rx_full_q, sclk_q;
  logic [DIV_W-1:0] div_q;
  logic [3:0]       tgt_q, code_q, rx_cs_q;
  logic [1:0]       ci_q, ss_s;
  logic [31:0]      cfg_q [NCS];
  logic [DW-1:0]    tx_data_q, rx_data_q, txsr_q, rxsr_q;
  logic [CW-1:0]    cnt_q;
  logic [5:0]       ec_q;

  wire [31:0] cfg_t  = cfg_q[tgt_q[1:0]];
  wire [31:0] cfg_c  = cfg_q[ci_q];
  wire [4:0]  len_t  = len_of(cfg_t[3:0]);
  wire [4:0]  len_c  = len_of(cfg_c[3:0]);
  wire        cpha   = cfg_c[5];
  wire        lead   = ~ec_q[0];
  wire        samp   = lead ^ cpha;
  wire        shft   = cpha ? (lead && ec_q != 6'd0) : ~lead;
  wire [5:0]  ec_end = {len_c, 1'b0} - 6'd1;
  wire [DW-1:0] rx_nx   = samp ? {rxsr_q[DW-2:0], miso} : rxsr_q;
  wire [DW-1:0] rx_mask = DW'((17'd1 << len_c) - 17'd1);
  wire        active = (st_q == S_LEAD) || (st_q == S_SHIFT);
  wire        go     = (st_q == S_IDLE) && en_q && !fault_q && tx_full_q && (div_q != '0);
  wire        rd_rx  = reg_rd && reg_addr == 4'd3;
  wire        rd_st  = reg_rd && reg_addr == 4'd4;
  wire        f_hit  = en_q && mfe_q && !ss_s[1];
  wire [CW-1:0] half = CW'(div_q) - CW'(1);

  assign sclk   = sclk_q;
  assign mosi   = txsr_q[DW-1];
  assign cs_n   = !active ? 4'hF : (enc_q ? code_q : ~(4'b0001 << code_q[1:0]));
  assign drv_en = en_q && !fault_q;
  assign tx_req = en_q && !fault_q && !tx_full_q;
  assign rx_req = rx_full_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[3]) reg_rdata = cfg_q[reg_addr[1:0]];
    else case (reg_addr)
      4'd0: reg_rdata = {16'd0, 8'(div_q), 5'd0, mfe_q, enc_q, en_q};
      4'd1: reg_rdata = {28'd0, tgt_q};
      4'd3: reg_rdata = {12'd0, rx_cs_q, rx_data_q};
      4'd4: reg_rdata = {20'd0, rx_cs_q, 3'd0, st_q != S_IDLE, fault_q, ovr_q, tx_full_q, rx_full_q};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; en_q <= 1'b0; enc_q <= 1'b0; mfe_q <= 1'b0; div_q <= '0;
      fault_q <= 1'b0; ovr_q <= 1'b0; tx_full_q <= 1'b0; rx_full_q <= 1'b0;
      sclk_q <= 1'b0; tgt_q <= '0; code_q <= '0; rx_cs_q <= '0; ci_q <= '0;
      ss_s <= 2'b11; tx_data_q <= '0; rx_data_q <= '0; txsr_q <= '0; rxsr_q <= '0;
      cnt_q <= '0; ec_q <= '0;
      for (int i = 0; i < NCS; i++) cfg_q[i] <= '0;
    end else begin
      ss_s <= {ss_s[0], ss_n_in};
      if (rd_rx) rx_full_q <= 1'b0;
      if (rd_st) begin ovr_q <= 1'b0; fault_q <= 1'b0; end

      case (st_q)
        S_IDLE: begin
          sclk_q <= cfg_t[4];
          if (go) begin
            ci_q <= tgt_q[1:0]; code_q <= tgt_q; tx_full_q <= 1'b0;
            txsr_q <= tx_data_q << (5'(DW) - len_t);
            rxsr_q <= '0; ec_q <= '0;
            cnt_q <= CW'(cfg_t[SU_LO +: DLY_W]);
            st_q <= S_LEAD;
          end
        end
        S_LEAD: begin
          if (cnt_q == '0) begin st_q <= S_SHIFT; cnt_q <= half; end
          else cnt_q <= cnt_q - CW'(1);
        end
        S_SHIFT: begin
          if (cnt_q == '0) begin
            cnt_q <= half; sclk_q <= ~sclk_q; ec_q <= ec_q + 6'd1;
            rxsr_q <= rx_nx;
            if (shft) txsr_q <= txsr_q << 1;
            if (ec_q == ec_end) begin
              rx_data_q <= rx_nx & rx_mask; rx_cs_q <= code_q; rx_full_q <= 1'b1;
              if (rx_full_q && !rd_rx) ovr_q <= 1'b1;
              cnt_q <= CW'(cfg_c[GP_LO +: DLY_W]);
              st_q <= S_REST;
            end
          end else cnt_q <= cnt_q - CW'(1);
        end
        default: begin
          if (cnt_q == '0) st_q <= S_IDLE;
          else cnt_q <= cnt_q - CW'(1);
        end
      endcase

      if (f_hit) fault_q <= 1'b1;
      if (f_hit || !en_q) begin
        if (st_q == S_LEAD || st_q == S_SHIFT) st_q <= S_IDLE;
      end

      if (reg_wr) begin
        if (reg_addr[3]) cfg_q[reg_addr[1:0]] <= reg_wdata;
        else case (reg_addr)
          4'd0: begin
            en_q <= reg_wdata[0]; enc_q <= reg_wdata[1]; mfe_q <= reg_wdata[2];
            div_q <= reg_wdata[8 +: DIV_W];
          end
          4'd1: tgt_q <= reg_wdata[3:0];
          4'd2: begin tx_data_q <= reg_wdata[DW-1:0]; tx_full_q <= 1'b1; end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_multi_master_chk.sv
module spi_multi_master_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       cs_n,
  input logic             enc,
  input logic [DIV_W-1:0] div,
  input logic             fault,
  input logic             drv_en,
  input logic             rx_full,
  input logic             ovr
);
  AST_DIRECT_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !enc |-> $onehot0(~cs_n));                                          // R2
  AST_DIV_ZERO_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0 && cs_n == 4'hF) |=> cs_n == 4'hF);                      // R8
  AST_OVERRUN_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rx_full));                                     // R10
  AST_FAULT_RELEASES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (cs_n == 4'hF && !drv_en));                               // R11
endmodule

bind spi_multi_master spi_multi_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .enc(enc_q), .div(div_q),
  .fault(fault_q), .drv_en(drv_en), .rx_full(rx_full_q), .ovr(ovr_q)
);

// File: tb/spi_multi_master_tb.sv
module spi_multi_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sclk, mosi, miso, drv_en, tx_req, rx_req;
  logic [3:0]  cs_n;
  logic        ss_n_in = 1'b1;

  int total = 0, fails = 0, cyc = 0;

  spi_multi_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n), .ss_n_in(ss_n_in), .drv_en(drv_en), .tx_req(tx_req), .rx_req(rx_req)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // slave model
  logic [15:0] sl_sr = '0, cap = '0;
  int          nsamp = 0;
  bit          m_cpol = 0, m_cpha = 0, armed = 0;
  logic [3:0]  cs_seen = 4'hF;
  assign miso = sl_sr[15];

  always @(sclk) begin
    if (armed) begin
      if ((sclk != m_cpol) ^ m_cpha) begin cap = {cap[14:0], mosi}; nsamp++; end
      else if (!(m_cpha && nsamp == 0)) sl_sr = sl_sr << 1;
    end
  end

  always @(negedge clk) if (cs_n != 4'hF) cs_seen = cs_n;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  function automatic logic [31:0] ctrl(input bit en, input bit enc, input bit mfe, input logic [7:0] dv);
    return {16'd0, dv, 5'd0, mfe, enc, en};
  endfunction

  function automatic logic [31:0] cfgw(input logic [3:0] lc, input bit cpol, input bit cpha,
                                       input logic [7:0] su, input logic [7:0] gp);
    return {8'd0, gp, su, 2'b00, cpha, cpol, lc};
  endfunction

  task automatic wait_rx(input string req);
    int n = 0;
    while (!rx_req && n < 5000) begin @(negedge clk); n++; end
    chk(n < 5000, req, n, 5000);
  endtask

  task automatic wait_cs(input bit low);
    int n = 0;
    while (((cs_n != 4'hF) != low) && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic do_xfer(input logic [3:0] tg, input logic [3:0] lc, input bit cpol, input bit cpha,
                         input logic [15:0] mv, input logic [15:0] sv, input logic [3:0] exp_cs);
    logic [31:0] d;
    int L = (lc > 4'd8) ? 16 : 8 + int'(lc);
    logic [15:0] mask = 16'((17'd1 << L) - 17'd1);
    armed = 0;
    wr(4'd8 + {2'b00, tg[1:0]}, cfgw(lc, cpol, cpha, 8'd2, 8'd0));
    wr(4'd1, {28'd0, tg});
    @(negedge clk);
    chk(sclk == cpol, "R5 idle sclk level", sclk, cpol);
    m_cpol = cpol; m_cpha = cpha;
    sl_sr = sv << (16 - L); cap = '0; nsamp = 0; cs_seen = 4'hF; armed = 1;
    wr(4'd2, {16'd0, mv});
    wait_rx("R12 rx_req after word");
    armed = 0;
    chk(cs_seen == exp_cs, "R2/R3 select pattern", cs_seen, exp_cs);
    chk(cap == (mv & mask), "R4 mosi MSB-first bits", cap, mv & mask);
    chk(nsamp == L, "R5 sampling edges", nsamp, L);
    rd(4'd3, d);
    chk(d[15:0] == (sv & mask), "R4 received word", d[15:0], sv & mask);
    chk(d[19:16] == tg, "R9 received select code", d[19:16], tg);
    rd(4'd4, d);
    chk(d[0] == 1'b0 && rx_req == 1'b0, "R9 holding emptied by read", d[0], 0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(cs_n == 4'hF, "R1 cs_n", cs_n, 4'hF);
    chk({drv_en, tx_req, rx_req} == 3'b000, "R1 strobes", {drv_en, tx_req, rx_req}, 0);
    rd(4'd4, d);
    chk(d == 0, "R1 status", d, 0);
    wr(4'd0, ctrl(1, 0, 0, 8'd2));
    @(negedge clk);
    chk(tx_req && drv_en, "R12 tx_req when idle and enabled", {tx_req, drv_en}, 2'b11);
  endtask

  task automatic t_direct;
    do_xfer(4'd0, 4'd0,  0, 0, 16'h00A5, 16'h003C, 4'b1110);
    do_xfer(4'd1, 4'd8,  1, 0, 16'hBEEF, 16'h1234, 4'b1101);
    do_xfer(4'd2, 4'd4,  0, 1, 16'h0ABC, 16'h05A3, 4'b1011);
    do_xfer(4'd3, 4'd15, 1, 1, 16'h8001, 16'hC3E1, 4'b0111);
  endtask

  task automatic t_coded;
    wr(4'd0, ctrl(1, 1, 0, 8'd2));
    do_xfer(4'hA, 4'd2, 1, 0, 16'h0321, 16'h02F0, 4'hA);
    wr(4'd0, ctrl(1, 0, 0, 8'd2));
  endtask

  task automatic meas_lead(input logic [7:0] dl, output int n);
    logic [31:0] d;
    wr(4'd8, cfgw(4'd0, 0, 0, dl, 8'd0));
    wr(4'd1, 32'd0);
    wr(4'd2, 32'h55);
    wait_cs(1);
    n = 0;
    while (sclk == 1'b0 && n < 5000) begin @(negedge clk); n++; end
    wait_rx("R6 word completes");
    rd(4'd3, d);
  endtask

  task automatic meas_rest(input logic [7:0] dl, output int n);
    logic [31:0] d;
    wr(4'd8, cfgw(4'd0, 0, 0, 8'd0, dl));
    wr(4'd1, 32'd0);
    wr(4'd2, 32'h11);
    wait_cs(1);
    wr(4'd2, 32'h22);
    wait_cs(0);
    n = 0;
    while (cs_n == 4'hF && n < 5000) begin @(negedge clk); n++; end
    wait_cs(0);
    repeat (3) @(negedge clk);
    rd(4'd4, d);
    rd(4'd3, d);
  endtask

  task automatic t_delays;
    int a, b;
    meas_lead(8'd0, a); meas_lead(8'd20, b);
    chk(b - a == 20, "R6 lead-in delay", b - a, 20);
    meas_rest(8'd0, a); meas_rest(8'd17, b);
    chk(b - a == 17, "R7 rest delay", b - a, 17);
  endtask

  task automatic t_divisor;
    logic [31:0] d;
    int n;
    wr(4'd0, ctrl(1, 0, 0, 8'd3));
    wr(4'd8, cfgw(4'd0, 0, 0, 8'd0, 8'd0));
    wr(4'd1, 32'd0);
    wr(4'd2, 32'h3C);
    n = 0;
    while (sclk == 1'b0 && n < 5000) begin @(negedge clk); n++; end
    n = 0;
    while (sclk == 1'b1 && n < 5000) begin @(negedge clk); n++; end
    chk(n == 3, "R8 half period", n, 3);
    wait_rx("R8 word completes");
    rd(4'd3, d);
    wr(4'd0, ctrl(1, 0, 0, 8'd0));
    wr(4'd2, 32'h99);
    repeat (50) @(negedge clk);
    chk(cs_n == 4'hF, "R8 zero divisor holds select", cs_n, 4'hF);
    chk(tx_req == 1'b0, "R12 no tx_req while word pending", tx_req, 0);
    rd(4'd4, d);
    chk(d[1] == 1'b1, "R8 word stays pending", d[1], 1);
    wr(4'd0, ctrl(1, 0, 0, 8'd2));
    wait_rx("R8 pending word sent");
    rd(4'd3, d);
  endtask

  task automatic t_overrun;
    logic [31:0] d;
    wr(4'd8, cfgw(4'd0, 0, 0, 8'd1, 8'd0));
    wr(4'd1, 32'd0);
    m_cpol = 0; m_cpha = 0;
    sl_sr = 16'h3300; armed = 1;
    wr(4'd2, 32'h11);
    wait_rx("R10 first word");
    wait_cs(0);
    sl_sr = 16'h4400;
    wr(4'd2, 32'h22);
    wait_cs(1); wait_cs(0);
    repeat (3) @(negedge clk);
    armed = 0;
    rd(4'd4, d);
    chk(d[2] == 1'b1 && d[0] == 1'b1, "R10 overrun set", d[2:0], 3'b101);
    rd(4'd4, d);
    chk(d[2] == 1'b0, "R10 overrun cleared by status read", d[2], 0);
    rd(4'd3, d);
    chk(d[7:0] == 8'h44, "R10 newer word kept", d[7:0], 8'h44);
  endtask

  task automatic t_fault;
    logic [31:0] d;
    wr(4'd0, ctrl(1, 0, 1, 8'd2));
    wr(4'd8, cfgw(4'd0, 0, 0, 8'd200, 8'd0));
    wr(4'd1, 32'd0);
    wr(4'd2, 32'h5A);
    wait_cs(1);
    ss_n_in = 1'b0;
    repeat (4) @(negedge clk);
    chk(drv_en == 1'b0 && cs_n == 4'hF, "R11 pins released on fault", {drv_en, cs_n}, 5'h0F);
    chk(tx_req == 1'b0, "R12 no tx_req under fault", tx_req, 0);
    ss_n_in = 1'b1;
    repeat (3) @(negedge clk);
    rd(4'd4, d);
    chk(d[3] == 1'b1 && d[4] == 1'b0, "R11 fault flag, word aborted", d[4:3], 2'b01);
    rd(4'd4, d);
    chk(d[3] == 1'b0 && drv_en == 1'b1, "R11 fault cleared by status read", {d[3], drv_en}, 2'b01);
    wr(4'd0, ctrl(1, 0, 0, 8'd2));
    ss_n_in = 1'b0;
    do_xfer(4'd1, 4'd0, 0, 0, 16'h00C7, 16'h0018, 4'b1101);
    rd(4'd4, d);
    chk(d[3] == 1'b0 && drv_en == 1'b1, "R11 slave-select ignored when off", {d[3], drv_en}, 2'b01);
    ss_n_in = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_direct;
    t_coded;
    t_delays;
    t_divisor;
    t_overrun;
    t_fault;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule